// File: doc/BRIEF.md
# Dual-Channel PCM Serial Receive Deframer

This block sits between a serial voice-data link and a two-channel converter. It samples a bit clock, a receive frame sync, a transmit frame sync and two serial data lines with a fast free-running system clock. From these it recovers one 8-bit PCM sample per channel per frame. Each new byte appears on a parallel output register together with a one-cycle valid strobe. A static mode input chooses the line layout. In per-line layout, each channel has its own data line. In shared-line layout, both channels travel back to back on the second line.

The block also watches for a dead link. When the bit clock stops toggling, or when either frame sync stops producing rising edges, it raises a power-save flag. While that flag is high, no samples are delivered. The block leaves power-save on the first receive-sync rising edge that arrives while the bit clock is running, and that edge also starts a fresh frame.

The deframer is a four-state machine. `ST_SAVE` is the power-save state and is entered from reset. `ST_CH1` collects the first byte. `ST_CH2` collects the second byte in shared-line layout only. `ST_HOLD` waits out the rest of the frame. The transitions are:
- resume: `ST_SAVE` to `ST_CH1` on a sync rise while the bit clock is active.
- restart: any active state to `ST_CH1` on a sync rise.
- split: `ST_CH1` to `ST_CH2` after the eighth bit in shared-line layout.
- finish: `ST_CH1` to `ST_HOLD` after the eighth bit in per-line layout, and `ST_CH2` to `ST_HOLD` after its eighth bit.
- stall: any active state to `ST_SAVE` on a stall.

Top module: `pcm_rx_dual`

## Requirements
- R1: While reset is held and right after it, `power_save` is 1, both byte outputs are 0x00 and neither valid strobe is high.
- R2: Each input passes two synchronizer flops and one edge register, so the design reacts on the third system clock edge after an input change. One data bit is taken on each falling bit-clock edge. The first bit after a receive-sync rising edge is the sample's most significant bit (bit 7).
- R3: With `mode_serial`=0, `din_a` feeds channel 1 and `din_b` feeds channel 2. After the eighth bit of a frame, both bytes are loaded and both valid strobes pulse in the same cycle.
- R4: With `mode_serial`=1, `din_a` has no effect. Bit slots 0–7 of `din_b` form the channel-1 byte and slots 8–15 form the channel-2 byte. Each byte gets its own strobe, at the end of its own slot group.
- R5: Each valid strobe lasts exactly one system cycle. A byte output changes only in a cycle where its strobe is high, and otherwise holds its value.
- R6: Bits that arrive after the last slot of a frame are ignored until the next receive-sync rising edge. They cause no extra strobe and do not change the bytes.
- R7: A receive-sync rising edge in the middle of a byte restarts collection at slot 0. The partial byte is discarded.
- R8: `power_save` goes to 1 once the bit clock has shown no edge for `BCLK_STALL_CLKS` system cycles.
- R9: `power_save` goes to 1 once `SYNC_STALL_BCLKS` falling bit-clock edges pass without a rising edge of `rsync`, or without a rising edge of `xsync`.
- R10: `power_save` clears only on a receive-sync rising edge seen while the bit clock is not stalled. That edge starts a frame at slot 0 and zeroes both sync-stall counts. No strobe is raised while `power_save` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bclk | input | 1 | serial bit clock, asynchronous to clk |
| rsync | input | 1 | receive frame sync |
| xsync | input | 1 | transmit frame sync, watched only for stalls |
| din_a | input | 1 | channel-1 serial data in per-line layout |
| din_b | input | 1 | channel-2 data, or both channels in shared-line layout |
| mode_serial | input | 1 | 0 = per-line layout, 1 = shared-line layout |
| ch1_byte | output | SAMPLE_W | last channel-1 sample |
| ch1_valid | output | 1 | one-cycle strobe when ch1_byte loads |
| ch2_byte | output | SAMPLE_W | last channel-2 sample |
| ch2_valid | output | 1 | one-cycle strobe when ch2_byte loads |
| power_save | output | 1 | link-stalled indication |

## Verification
The assertions assume that each bit-clock half period spans several system cycles, so that any two strobes are far apart. They also assume that `mode_serial` changes only between frames and that sync edges fall on rising bit-clock edges, never on falling ones. The stimulus drives every line at system-clock falling edges with an eight-cycle bit-clock half period. Syncs and data change together with the bit-clock rise, and the mode changes only between frames. Stalls are made by freezing the bit clock or by leaving out sync pulses for two frame lengths.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
    typedef enum logic [1:0] {
        ST_SAVE = 2'd0,
        ST_CH1  = 2'd1,
        ST_CH2  = 2'd2,
        ST_HOLD = 2'd3
    } rx_state_e;
endpackage

// File: rtl/pcm_rx_sync.sv
// Two-flop synchronizer, one lane per asynchronous input.
module pcm_rx_sync #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] lvl
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic meta_q;
        logic safe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                safe_q <= 1'b0;
            end else begin
                meta_q <= async_in[i];
                safe_q <= meta_q;
            end
        end
        assign lvl[i] = safe_q;
    end
endmodule

// File: rtl/pcm_rx_edge.sv
// Registers the previous level and reports a change on any lane.
module pcm_rx_edge #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] chg
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= lvl[i];
        end
        assign chg[i] = lvl[i] ^ prev_q;
    end
endmodule

// File: rtl/pcm_rx_stall_mon.sv
// Idle counter on the bit clock and edge-count watchdogs on both syncs.
module pcm_rx_stall_mon #(
    parameter int BCLK_STALL_CLKS  = 4096,
    parameter int SYNC_STALL_BCLKS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_edge,
    input  logic bclk_fall,
    input  logic rsync_rise,
    input  logic xsync_rise,
    input  logic restart,
    output logic bclk_stall,
    output logic sync_stall
);
    localparam int IW = $clog2(BCLK_STALL_CLKS + 1);
    localparam int SW = $clog2(SYNC_STALL_BCLKS + 1);
    localparam logic [IW-1:0] IDLE_MAX = IW'(BCLK_STALL_CLKS);
    localparam logic [SW-1:0] SYNC_MAX = SW'(SYNC_STALL_BCLKS);

    logic [IW-1:0] idle_q;
    logic [SW-1:0] rcnt_q;
    logic [SW-1:0] xcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               idle_q <= '0;
        else if (bclk_edge)       idle_q <= '0;
        else if (idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              rcnt_q <= '0;
        else if (rsync_rise || restart)          rcnt_q <= '0;
        else if (bclk_fall && rcnt_q != SYNC_MAX) rcnt_q <= rcnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              xcnt_q <= '0;
        else if (xsync_rise || restart)          xcnt_q <= '0;
        else if (bclk_fall && xcnt_q != SYNC_MAX) xcnt_q <= xcnt_q + 1'b1;
    end

    assign bclk_stall = (idle_q == IDLE_MAX);
    assign sync_stall = (rcnt_q == SYNC_MAX) || (xcnt_q == SYNC_MAX);
endmodule

// File: rtl/pcm_rx_deframer.sv
// Frame state machine: collects bits into per-channel bytes.
module pcm_rx_deframer
    import pcm_rx_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic                frame_start,
    input  logic                din_a,
    input  logic                din_b,
    input  logic                mode_serial,
    input  logic                bclk_stall,
    input  logic                any_stall,
    output logic [SAMPLE_W-1:0] ch1_byte,
    output logic                ch1_valid,
    output logic [SAMPLE_W-1:0] ch2_byte,
    output logic                ch2_valid,
    output logic                power_save,
    output logic                leave_save
);
    localparam int CW = (SAMPLE_W > 2) ? $clog2(SAMPLE_W) : 1;
    localparam logic [CW-1:0] LAST_SLOT = CW'(SAMPLE_W - 1);

    rx_state_e state_q, state_d;
    logic [CW-1:0]       bit_cnt_q;
    logic [SAMPLE_W-2:0] sr_a_q;
    logic [SAMPLE_W-2:0] sr_b_q;
    logic                last_bit;
    logic                collecting;

    assign last_bit   = (bit_cnt_q == LAST_SLOT);
    assign collecting = (state_q == ST_CH1) || (state_q == ST_CH2);
    assign leave_save = (state_q == ST_SAVE) && frame_start && !bclk_stall;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAVE: begin
                if (leave_save) state_d = ST_CH1;          // resume
            end
            ST_CH1: begin
                if (any_stall)                 state_d = ST_SAVE;   // stall
                else if (frame_start)          state_d = ST_CH1;    // restart
                else if (bit_tick && last_bit) state_d = mode_serial ? ST_CH2 : ST_HOLD;
            end
            ST_CH2: begin
                if (any_stall)                 state_d = ST_SAVE;
                else if (frame_start)          state_d = ST_CH1;
                else if (bit_tick && last_bit) state_d = ST_HOLD;   // finish
            end
            ST_HOLD: begin
                if (any_stall)        state_d = ST_SAVE;
                else if (frame_start) state_d = ST_CH1;
            end
            default: state_d = ST_SAVE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SAVE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            sr_a_q     <= '0;
            sr_b_q     <= '0;
            ch1_byte   <= '0;
            ch2_byte   <= '0;
            ch1_valid  <= 1'b0;
            ch2_valid  <= 1'b0;
            power_save <= 1'b1;
        end else begin
            ch1_valid  <= 1'b0;
            ch2_valid  <= 1'b0;
            power_save <= (state_d == ST_SAVE);
            if (state_d == ST_SAVE) begin
                bit_cnt_q <= '0;
            end else if (frame_start) begin
                bit_cnt_q <= '0;
                sr_a_q    <= '0;
                sr_b_q    <= '0;
            end else if (bit_tick && collecting) begin
                sr_a_q    <= {sr_a_q[SAMPLE_W-3:0], din_a};
                sr_b_q    <= {sr_b_q[SAMPLE_W-3:0], din_b};
                bit_cnt_q <= last_bit ? '0 : bit_cnt_q + 1'b1;
                if (last_bit) begin
                    if (state_q == ST_CH1) begin
                        if (mode_serial) begin
                            ch1_byte  <= {sr_b_q, din_b};
                            ch1_valid <= 1'b1;
                        end else begin
                            ch1_byte  <= {sr_a_q, din_a};
                            ch2_byte  <= {sr_b_q, din_b};
                            ch1_valid <= 1'b1;
                            ch2_valid <= 1'b1;
                        end
                    end else begin
                        ch2_byte  <= {sr_b_q, din_b};
                        ch2_valid <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pcm_rx_dual.sv
module pcm_rx_dual #(
    parameter int SAMPLE_W         = 8,
    parameter int BCLK_STALL_CLKS  = 4096,
    parameter int SYNC_STALL_BCLKS = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk,
    input  logic                rsync,
    input  logic                xsync,
    input  logic                din_a,
    input  logic                din_b,
    input  logic                mode_serial,
    output logic [SAMPLE_W-1:0] ch1_byte,
    output logic                ch1_valid,
    output logic [SAMPLE_W-1:0] ch2_byte,
    output logic                ch2_valid,
    output logic                power_save
);
    // lanes: 0 bclk, 1 rsync, 2 xsync, 3 din_a, 4 din_b
    logic [4:0] lvl;
    logic [2:0] chg;
    logic       bclk_fall;
    logic       rsync_rise;
    logic       xsync_rise;
    logic       bclk_stall;
    logic       sync_stall;
    logic       leave_save;

    pcm_rx_sync #(.N(5)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({din_b, din_a, xsync, rsync, bclk}),
        .lvl      (lvl)
    );

    pcm_rx_edge #(.N(3)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl[2:0]),
        .chg   (chg)
    );

    assign bclk_fall  = chg[0] & ~lvl[0];
    assign rsync_rise = chg[1] &  lvl[1];
    assign xsync_rise = chg[2] &  lvl[2];

    pcm_rx_stall_mon #(
        .BCLK_STALL_CLKS  (BCLK_STALL_CLKS),
        .SYNC_STALL_BCLKS (SYNC_STALL_BCLKS)
    ) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_edge  (chg[0]),
        .bclk_fall  (bclk_fall),
        .rsync_rise (rsync_rise),
        .xsync_rise (xsync_rise),
        .restart    (leave_save),
        .bclk_stall (bclk_stall),
        .sync_stall (sync_stall)
    );

    pcm_rx_deframer #(.SAMPLE_W(SAMPLE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bclk_fall),
        .frame_start (rsync_rise),
        .din_a       (lvl[3]),
        .din_b       (lvl[4]),
        .mode_serial (mode_serial),
        .bclk_stall  (bclk_stall),
        .any_stall   (bclk_stall | sync_stall),
        .ch1_byte    (ch1_byte),
        .ch1_valid   (ch1_valid),
        .ch2_byte    (ch2_byte),
        .ch2_valid   (ch2_valid),
        .power_save  (power_save),
        .leave_save  (leave_save)
    );
endmodule

// File: rtl/pcm_rx_dual_chk.sv
module pcm_rx_dual_chk #(
    parameter int SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mode_serial,
    input logic [SAMPLE_W-1:0] ch1_byte,
    input logic                ch1_valid,
    input logic [SAMPLE_W-1:0] ch2_byte,
    input logic                ch2_valid,
    input logic                power_save,
    input logic                bclk_stall,
    input logic                sync_stall
);
    p_pulse1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ch1_valid |=> !ch1_valid);
    p_pulse2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ch2_valid |=> !ch2_valid);
    p_hold1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch1_byte) |-> ch1_valid);
    p_hold2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch2_byte) |-> ch2_valid);
    p_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_valid && !$past(mode_serial)) |-> ch2_valid);
    p_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_valid && $past(mode_serial)) |-> !ch2_valid);
    p_bclk_save_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_stall |=> power_save);
    p_sync_save_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_stall && !power_save) |=> power_save);
    p_quiet_save_r10: assert property (@(posedge clk) disable iff (!rst_n)
        power_save |-> (!ch1_valid && !ch2_valid));
    p_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(power_save) |-> !$past(bclk_stall));
endmodule

bind pcm_rx_dual pcm_rx_dual_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_serial (mode_serial),
    .ch1_byte    (ch1_byte),
    .ch1_valid   (ch1_valid),
    .ch2_byte    (ch2_byte),
    .ch2_valid   (ch2_valid),
    .power_save  (power_save),
    .bclk_stall  (bclk_stall),
    .sync_stall  (sync_stall)
);

// File: tb/pcm_rx_dual_bench.sv
module pcm_rx_dual_bench;
    localparam int BT   = 40;
    localparam int ST   = 48;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, rsync = 1'b0, xsync = 1'b0;
    logic din_a = 1'b0, din_b = 1'b0, mode_serial = 1'b0;
    logic [7:0] ch1_byte, ch2_byte;
    logic ch1_valid, ch2_valid, power_save;

    always #2.5 clk = ~clk;

    pcm_rx_dual #(.SAMPLE_W(8), .BCLK_STALL_CLKS(BT), .SYNC_STALL_BCLKS(ST)) u_pcm_rx_dual (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .rsync(rsync), .xsync(xsync),
        .din_a(din_a), .din_b(din_b), .mode_serial(mode_serial),
        .ch1_byte(ch1_byte), .ch1_valid(ch1_valid), .ch2_byte(ch2_byte),
        .ch2_valid(ch2_valid), .power_save(power_save)
    );

    int total = 0;
    int fails = 0;
    int n1 = 0;
    int n2 = 0;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [4:0] h0 = '0, h1 = '0, h2 = '0;
    int m_state = 0, m_cnt = 0, m_idle = 0, m_rc = 0, m_xc = 0;
    logic [7:0] m_a = '0, m_b = '0, m_ch1 = '0, m_ch2 = '0;
    logic m_v1 = 0, m_v2 = 0, m_ps = 1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h0 = '0; h1 = '0; h2 = '0;
            m_state = 0; m_cnt = 0; m_idle = 0; m_rc = 0; m_xc = 0;
            m_a = '0; m_b = '0; m_ch1 = '0; m_ch2 = '0;
            m_v1 = 0; m_v2 = 0; m_ps = 1;
        end else begin
            logic bedge, bfall, rrise, xrise, bst, sst, leave;
            bedge = h1[0] != h2[0];
            bfall = bedge && !h1[0];
            rrise = h1[1] && !h2[1];
            xrise = h1[2] && !h2[2];
            bst = m_idle >= BT;
            sst = (m_rc >= ST) || (m_xc >= ST);
            leave = (m_state == 0) && rrise && !bst;
            m_v1 = 0; m_v2 = 0;
            if (m_state == 0) begin
                if (leave) begin m_state = 1; m_cnt = 0; end
            end else if (bst || sst) begin
                m_state = 0;
            end else if (rrise) begin
                m_state = 1; m_cnt = 0;
            end else if (bfall && (m_state == 1 || m_state == 2)) begin
                m_a = {m_a[6:0], h1[3]};
                m_b = {m_b[6:0], h1[4]};
                m_cnt++;
                if (m_cnt == 8) begin
                    m_cnt = 0;
                    if (m_state == 1) begin
                        if (mode_serial) begin
                            m_ch1 = m_b; m_v1 = 1; m_state = 2;
                        end else begin
                            m_ch1 = m_a; m_ch2 = m_b; m_v1 = 1; m_v2 = 1; m_state = 3;
                        end
                    end else begin
                        m_ch2 = m_b; m_v2 = 1; m_state = 3;
                    end
                end
            end
            m_ps = (m_state == 0);
            m_idle = bedge ? 0 : (m_idle < BT ? m_idle + 1 : BT);
            if (rrise || leave) m_rc = 0; else if (bfall && m_rc < ST) m_rc++;
            if (xrise || leave) m_xc = 0; else if (bfall && m_xc < ST) m_xc++;
            h2 = h1; h1 = h0;
            h0 = {din_b, din_a, xsync, rsync, bclk};
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 ch1_byte vs model", {24'd0, ch1_byte}, {24'd0, m_ch1});
            chk("R4 ch2_byte vs model", {24'd0, ch2_byte}, {24'd0, m_ch2});
            chk("R5 strobes vs model", {30'd0, ch1_valid, ch2_valid}, {30'd0, m_v1, m_v2});
            chk("R8 power_save vs model", {31'd0, power_save}, {31'd0, m_ps});
            if (ch1_valid) n1++;
            if (ch2_valid) n2++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic bit_period(input logic s, input logic x, input logic a, input logic b);
        bclk = 1'b1; rsync = s; xsync = x; din_a = a; din_b = b;
        repeat (HALF) @(negedge clk);
        bclk = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame(input bit ser, input logic [7:0] b1, input logic [7:0] b2,
                         input bit rs_en, input bit xs_en, input int nper);
        mode_serial = ser;
        for (int s = 0; s < nper; s++) begin
            logic a, b, junk;
            junk = 1'($urandom_range(0, 1));
            if (ser) begin
                a = 1'($urandom_range(0, 1));
                b = (s < 8) ? b1[7-s] : (s < 16) ? b2[15-s] : junk;
            end else begin
                a = (s < 8) ? b1[7-s] : junk;
                b = (s < 8) ? b2[7-s] : 1'($urandom_range(0, 1));
            end
            bit_period(rs_en && s == 0, xs_en && s == 0, a, b);
        end
    endtask

    task automatic good_frame(input string req, input bit ser, input logic [7:0] b1, input logic [7:0] b2);
        int s1, s2;
        s1 = n1; s2 = n2;
        frame(ser, b1, b2, 1, 1, 32);
        chk({req, " ch1 byte"}, {24'd0, ch1_byte}, {24'd0, b1});
        chk({req, " ch2 byte"}, {24'd0, ch2_byte}, {24'd0, b2});
        chk({req, " one ch1 strobe"}, n1 - s1, 1);
        chk({req, " one ch2 strobe"}, n2 - s2, 1);
        chk({req, " power_save low"}, {31'd0, power_save}, 0);
    endtask

    initial begin
        int s1;
        repeat (3) @(negedge clk);
        chk("R1 power_save in reset", {31'd0, power_save}, 1);
        chk("R1 bytes zero in reset", {16'd0, ch1_byte, ch2_byte}, 0);
        chk("R1 no strobe in reset", {30'd0, ch1_valid, ch2_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 power_save after reset", {31'd0, power_save}, 1);

        good_frame("R3", 0, 8'hA5, 8'h3C);
        good_frame("R2 msb first", 0, 8'h80, 8'h01);
        good_frame("R6 trailing bits", 0, 8'hFF, 8'h00);
        good_frame("R4", 1, 8'h5A, 8'hC3);
        good_frame("R4 din_a ignored", 1, 8'h01, 8'h80);

        // R7: sync restart in mid byte
        s1 = n1;
        frame(0, 8'h11, 8'h22, 1, 1, 4);
        frame(0, 8'h6E, 8'h91, 1, 1, 32);
        chk("R7 restart byte", {16'd0, ch1_byte, ch2_byte}, {16'd0, 8'h6E, 8'h91});
        chk("R7 partial discarded", n1 - s1, 1);

        // R8: bit clock stall
        repeat (60) @(negedge clk);
        chk("R8 bclk stall", {31'd0, power_save}, 1);
        s1 = n1;
        frame(0, 8'h77, 8'h44, 1, 1, 32);   // sync coincides with renewed bclk
        chk("R10 no exit on coincident sync", {31'd0, power_save}, 1);
        chk("R10 no strobe while saving", n1 - s1, 0);
        chk("R10 bytes held", {16'd0, ch1_byte, ch2_byte}, {16'd0, 8'h6E, 8'h91});
        good_frame("R10 resume", 0, 8'h3D, 8'hB2);

        // R9: transmit sync stall
        frame(0, 8'h12, 8'h34, 1, 0, 32);
        chk("R9 xsync stall byte", {24'd0, ch1_byte}, 8'h12);
        chk("R9 xsync stall", {31'd0, power_save}, 1);
        good_frame("R10 resume after xsync stall", 1, 8'hE7, 8'h18);

        // R9: receive sync stall
        frame(1, 8'h00, 8'h00, 0, 1, 32);
        frame(1, 8'h00, 8'h00, 0, 1, 32);
        chk("R9 rsync stall", {31'd0, power_save}, 1);
        good_frame("R10 resume after rsync stall", 0, 8'hC9, 8'h2F);

        repeat (20) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule